// File: doc/BRIEF.md
# Multi-Mode Single-Cycle Barrel Shifter

This block is the shift unit of a 16-bit accumulator processor. Each cycle it takes an operand word, a 4-bit shift distance that comes from the instruction field, a carry-in and a 3-bit operation code. It registers the shifted word, a carry-out, a zero flag and a negative flag on the next rising clock edge. A shift by any distance costs the same single cycle as a shift by one.

Eight operations are supported:

- Logical shifts left and right.
- Arithmetic shift right, which replicates the sign bit.
- Rotates in both directions by any distance. These rotates keep the carry out of the loop, so the word turns on its own.
- Single-bit rotates through the carry, in both directions. These let software chain rotates across several words.
- A pass-through code.

Internally a control decoder turns the operation code into a few strobes. A log-depth right-shift network serves every mode, and left-going modes mirror the word around that network.

Top module: `barrelShiftUnit`

## Requirements
- R1: Code 0 (shift left): the result is the operand moved left by the distance, with zeros entering at bit 0. The carry-out is the last bit pushed out of bit 15, which is operand bit 16 minus the distance.
- R2: Code 1 (logical shift right): the result is the operand moved right by the distance, with zeros entering at bit 15. The carry-out is operand bit distance minus one.
- R3: Code 2 (arithmetic shift right): like R2, except that the vacated high bits take copies of the original operand bit 15.
- R4: Codes 3 (rotate left) and 4 (rotate right): the bits leaving one end of the word re-enter at the other end. Any distance from 0 to 15 is accepted. The carry-out equals the carry-in. Rotating left by N and then right by N restores the operand.
- R5: Codes 5 and 6 rotate through the carry by exactly one bit, whatever the distance field holds. Code 5 gives {operand[14:0], carryIn} with carry-out operand[15]. Code 6 gives {carryIn, operand[15:1]} with carry-out operand[0].
- R6: For codes 0, 1 and 2 with distance 0, the result equals the operand and the carry-out equals the carry-in.
- R7: The zero flag is 1 exactly when the registered result is all zeros.
- R8: The negative flag equals bit 15 of the registered result.
- R9: The outputs show the result of the inputs present at the previous rising clock edge, every cycle. While the active-low reset is asserted, all outputs are 0.
- R10: Code 7 passes the operand and the carry-in through unchanged, and the distance field has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opSel | input | 3 | Operation code (0 to 7, see R1 to R10) |
| shiftDist | input | 4 | Shift distance from the instruction |
| operandIn | input | 16 | Word to shift |
| carryIn | input | 1 | Carry flag in |
| resultOut | output | 16 | Registered shifted word |
| carryOut | output | 1 | Registered carry flag |
| zeroOut | output | 1 | Registered zero flag |
| negOut | output | 1 | Registered negative flag |

## Verification
Every output is due exactly one rising edge after its inputs are applied. The bench drives the inputs on the falling edge and pushes the expected tuple into a queue at that moment. The monitor pops one entry just after the following rising edge and compares all four outputs there, so each comparison falls in the first cycle in which the result is valid. The rotate round trip reads the first result in that same window before it drives the reverse rotate.

// File: rtl/shiftPkg.sv
package shiftPkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RCL  = 3'd5,
    OP_RCR  = 3'd6,
    OP_PASS = 3'd7
  } shiftOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic mirror;     // work in bit-reversed domain (left-going modes)
    logic wrap;       // bits leaving re-enter (rotate without carry)
    logic signFill;   // fill with operand sign bit
    logic carryFill;  // fill with carry-in (single-bit through carry)
    logic keepCarry;  // carry-out takes carry-in
  } shiftCtrl_t;
endpackage

// File: rtl/shiftControl.sv
module shiftControl
  import shiftPkg::*;
#(
  parameter int DIST_W = 4
) (
  input  logic [2:0]        opSel,
  input  logic [DIST_W-1:0] distIn,
  output shiftCtrl_t        ctrl,
  output logic [DIST_W-1:0] effDist
);
  shiftOp_e opCode;
  assign opCode = shiftOp_e'(opSel);

  always_comb begin
    ctrl    = '0;
    effDist = distIn;
    unique case (opCode)
      OP_SHL:  ctrl.mirror = 1'b1;
      OP_SHR:  ;
      OP_SAR:  ctrl.signFill = 1'b1;
      OP_ROL:  begin ctrl.mirror = 1'b1; ctrl.wrap = 1'b1; end
      OP_ROR:  ctrl.wrap = 1'b1;
      OP_RCL:  begin ctrl.mirror = 1'b1; ctrl.carryFill = 1'b1;
                     effDist = DIST_W'(1); end
      OP_RCR:  begin ctrl.carryFill = 1'b1; effDist = DIST_W'(1); end
      OP_PASS: effDist = '0;
      default: effDist = '0;
    endcase
    ctrl.keepCarry = ctrl.wrap || (effDist == '0);
  end

  // Fill sources are mutually exclusive (R3, R4, R5)
  always_comb begin
    a_fill_excl_r5: assert ($onehot0({ctrl.wrap, ctrl.signFill, ctrl.carryFill}));
  end
endmodule

// File: rtl/shiftDatapath.sv
module shiftDatapath
  import shiftPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIST_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shiftCtrl_t        ctrl,
  input  logic [DIST_W-1:0] effDist,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultQ,
  output logic              carryQ,
  output logic              zeroQ,
  output logic              negQ
);
  localparam int STAGES = DIST_W;

  logic [DATA_W-1:0] revIn, workIn, revOut, resultD;
  logic [DATA_W-1:0] stg [0:STAGES];
  logic              fillBit, lastOut, carryD;
  logic [DIST_W-1:0] lastIdx;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign revIn[gi]  = operand[DATA_W-1-gi];
      assign revOut[gi] = stg[STAGES][DATA_W-1-gi];
    end
  endgenerate

  assign workIn  = ctrl.mirror ? revIn : operand;
  assign fillBit = ctrl.carryFill ? carryIn :
                   ctrl.signFill  ? operand[DATA_W-1] : 1'b0;
  assign stg[0]  = workIn;

  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      localparam int S = 1 << gi;
      logic [DATA_W-1:0] moved;
      assign moved = ctrl.wrap ? {stg[gi][S-1:0], stg[gi][DATA_W-1:S]}
                               : {{S{fillBit}}, stg[gi][DATA_W-1:S]};
      assign stg[gi+1] = effDist[gi] ? moved : stg[gi];
    end
  endgenerate

  assign lastIdx = effDist - DIST_W'(1);
  assign lastOut = workIn[lastIdx];
  assign resultD = ctrl.mirror ? revOut : stg[STAGES];
  assign carryD  = ctrl.keepCarry ? carryIn : lastOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultQ <= '0;
      carryQ  <= 1'b0;
      zeroQ   <= 1'b0;
      negQ    <= 1'b0;
    end else begin
      resultQ <= resultD;
      carryQ  <= carryD;
      zeroQ   <= (resultD == '0);
      negQ    <= resultD[DATA_W-1];
    end
  end

  // Assertion support: one cycle of history exists
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  p_shl_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(ctrl.mirror && !ctrl.wrap && !ctrl.carryFill && effDist != '0)
    |-> resultQ[0] == 1'b0);

  p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(ctrl.signFill) |-> resultQ[DATA_W-1] == $past(operand[DATA_W-1]));

  p_rot_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(ctrl.wrap) |-> carryQ == $past(carryIn));

  p_rcl_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(ctrl.carryFill && ctrl.mirror)
    |-> resultQ[0] == $past(carryIn) && carryQ == $past(operand[DATA_W-1]));

  p_rcr_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(ctrl.carryFill && !ctrl.mirror)
    |-> resultQ[DATA_W-1] == $past(carryIn) && carryQ == $past(operand[0]));

  p_zero_dist_r6: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(effDist == '0)
    |-> resultQ == $past(operand) && carryQ == $past(carryIn));

  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    negQ == resultQ[DATA_W-1] && !(zeroQ && negQ));
endmodule

// File: rtl/barrelShiftUnit.sv
module barrelShiftUnit
  import shiftPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIST_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        opSel,
  input  logic [DIST_W-1:0] shiftDist,
  input  logic [DATA_W-1:0] operandIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut,
  output logic              zeroOut,
  output logic              negOut
);
  shiftCtrl_t        ctrl;
  logic [DIST_W-1:0] effDist;

  shiftControl #(.DIST_W(DIST_W)) u_ctrl (
    .opSel   (opSel),
    .distIn  (shiftDist),
    .ctrl    (ctrl),
    .effDist (effDist)
  );

  shiftDatapath #(.DATA_W(DATA_W), .DIST_W(DIST_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .effDist (effDist),
    .operand (operandIn),
    .carryIn (carryIn),
    .resultQ (resultOut),
    .carryQ  (carryOut),
    .zeroQ   (zeroOut),
    .negQ    (negOut)
  );
endmodule

// File: tb/barrelShiftUnit_test.sv
module barrelShiftUnit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  opSel = '0;
  logic [3:0]  shiftDist = '0;
  logic [15:0] operandIn = '0;
  logic        carryIn = 1'b0;
  logic [15:0] resultOut;
  logic        carryOut, zeroOut, negOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  barrelShiftUnit uut (
    .clk(clk), .rst_n(rst_n), .opSel(opSel), .shiftDist(shiftDist),
    .operandIn(operandIn), .carryIn(carryIn), .resultOut(resultOut),
    .carryOut(carryOut), .zeroOut(zeroOut), .negOut(negOut));

  typedef struct {
    logic [15:0] res;
    logic        cy;
    string       tag;
  } item_t;
  item_t sb[$];

  // Reference model, bit by bit from the requirements
  function automatic void refModel(input logic [2:0] op, input int n,
      input logic [15:0] a, input logic ci, output logic [15:0] r, output logic c);
    r = a; c = ci;
    case (op)
      3'd0: for (int i = 0; i < n; i++) begin c = r[15]; r = {r[14:0], 1'b0}; end // R1
      3'd1: for (int i = 0; i < n; i++) begin c = r[0]; r = {1'b0, r[15:1]}; end  // R2
      3'd2: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[15], r[15:1]}; end // R3
      3'd3: for (int i = 0; i < n; i++) r = {r[14:0], r[15]};                     // R4
      3'd4: for (int i = 0; i < n; i++) r = {r[0], r[15:1]};                      // R4
      3'd5: begin c = a[15]; r = {a[14:0], ci}; end                               // R5
      3'd6: begin c = a[0]; r = {ci, a[15:1]}; end                                // R5
      default: ;                                                                  // R10
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] op, input int n);
    if (op <= 3'd2 && n == 0) return "R6";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [2:0] op, input int n,
                       input logic [15:0] a, input logic ci);
    item_t it;
    @(negedge clk);
    opSel = op; shiftDist = 4'(n); operandIn = a; carryIn = ci;
    refModel(op, n, a, ci, it.res, it.cy);
    it.tag = tagOf(op, n);
    sb.push_back(it);
  endtask

  // Monitor: result due one rising edge after drive (R9)
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      checks++;
      if (resultOut !== e.res || carryOut !== e.cy) begin
        errors++;
        $display("FAIL %s/R9: res=%h cy=%b expected res=%h cy=%b",
                 e.tag, resultOut, carryOut, e.res, e.cy);
      end
      checks++;
      if (zeroOut !== (e.res == 16'h0) || negOut !== e.res[15]) begin
        errors++;
        $display("FAIL R7/R8 (%s): z=%b n=%b expected z=%b n=%b",
                 e.tag, zeroOut, negOut, (e.res == 16'h0), e.res[15]);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  localparam logic [15:0] PATS [6] = '{16'h0000, 16'hFFFF, 16'h8001,
                                       16'h1234, 16'hA5C3, 16'h7FFE};

  initial begin
    logic [15:0] mid;
    operandIn = 16'hBEEF; carryIn = 1'b1; opSel = 3'd3; shiftDist = 4'd5;
    repeat (3) @(posedge clk);
    #1;
    checks++; // R9 reset state
    if (resultOut !== 16'h0 || carryOut !== 1'b0 || zeroOut !== 1'b0 || negOut !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: res=%h c=%b z=%b n=%b expected all 0",
               resultOut, carryOut, zeroOut, negOut);
    end
    @(negedge clk); rst_n = 1'b1;

    // All modes, distances, carries and patterns (R1..R6, R10)
    for (int op = 0; op < 8; op++)
      for (int n = 0; n < 16; n++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++)
            drive(3'(op), n, PATS[p], 1'(c));

    // Rotate round trip restores operand (R4)
    for (int n = 0; n < 16; n++) begin
      drive(3'd3, n, 16'hC0DE ^ 16'(n), 1'b0);
      @(posedge clk); #2;
      mid = resultOut;
      drive(3'd4, n, mid, 1'b0);
      @(posedge clk); #2;
      checks++;
      if (resultOut !== (16'hC0DE ^ 16'(n))) begin
        errors++;
        $display("FAIL R4 round trip n=%0d: got %h expected %h",
                 n, resultOut, 16'hC0DE ^ 16'(n));
      end
    end

    repeat (4) @(posedge clk);
    #3;
    finishRun();
  end
endmodule